// File: doc/BRIEF.md
# Word-Interleaved Four-Bank Memory Controller

The controller connects a requester that moves one 32-bit word at a time to four independent memory banks. Each word address goes to a bank chosen by its low word-address bits, so a run of consecutive words visits bank 0, 1, 2, 3 and then bank 0 again. A new access can therefore start in the next bank while the previous bank is still in its cycle. Requests arrive on a valid/ready handshake, and at most one is accepted per clock. Each bank is a synchronous array. After it is accepted, an access keeps its bank busy for a fixed number of cycles. That busy time is longer than the access latency, the delay from the request to the data.

A request is stalled (ready low) while its target bank is still busy. The request must be held until the bank frees. Read data comes back in issue order as a one-cycle valid beat. A small queue records which bank each outstanding read is waiting on. A write is stored, occupies its bank for the full busy time, and produces no response beat.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, with no request pending, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The bank is byte-address bits [3:2] and the word within the bank is bits [ADDR_W-1:4]. Bits [1:0] are ignored, so a write to byte address 0x45 is read back at 0x44.
- R3: Two accepted requests to the same bank are at least BUSY_CYC (default 6) clock edges apart. A read directly after a write to the same bank is accepted exactly 6 edges after the write.
- R4: Requests to four different, idle banks are accepted on four consecutive edges. `req_ready` is 1 whenever the target bank is idle and the read queue has room.
- R5: Read data appears on `rsp_valid`/`rsp_rdata` ACC_LAT (default 4) edges after the accepting edge, and `rsp_valid` stays high for one cycle per read.
- R6: Every accepted read produces exactly one response and every write produces none. Responses come back in the order the reads were accepted.
- R7: A read returns the last data written to that word.
- R8: A request that is stalled on a busy bank is neither lost nor duplicated. It is accepted once the bank frees, and a stalled read then returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data beat valid |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The hardest situation to bring about from the ports combines two things. Several reads must be in flight across different banks at once, and a fresh request must stall behind a busy bank while earlier reads are still returning. Only then can the order and timing of responses go wrong. The stimulus gets there in three ways. It uses strided address runs that keep all four banks occupied, and it uses repeated hits on one bank that force stalls. It also mixes in long random traffic with occasional idle cycles, so that stalls, writes and returning reads overlap in many different phases.

// File: rtl/ilv_pkg.sv
// Shared constants and helpers for the interleaved memory controller.
// Assumes byte addressing with 32-bit words; bank count is a power of two.
package ilv_pkg;
    localparam int WORD_OFF_BITS = 2;   // byte offset within a word

    // Width of a counter that must hold values 0..maxval.
    function automatic int cnt_width(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction
endpackage

// File: rtl/ilv_addr_split.sv
// Splits a byte address into a bank number and a word index within the bank.
// Assumes word interleaving: the bank field sits directly above the byte offset.
module ilv_addr_split
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int IDX_W  = ADDR_W - WORD_OFF_BITS - BANK_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic unused_byte_off;

    // Field extraction; the byte offset has no effect on a word access.
    always_comb begin
        bank_o          = addr_i[WORD_OFF_BITS +: BANK_W];
        idx_o           = addr_i[ADDR_W-1 -: IDX_W];
        unused_byte_off = ^addr_i[WORD_OFF_BITS-1:0];
    end
endmodule

// File: rtl/ilv_bank.sv
// One memory bank: a synchronous word array with a busy countdown and a
// read latency countdown. Assumes BUSY_CYC >= ACC_LAT >= 1, so at most one
// read is pending per bank, and the read result is held until popped.
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 8,
    parameter int ACC_LAT  = 4,
    parameter int BUSY_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,     // access accepted this edge
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pop_i,     // pending read result consumed
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int BCW   = cnt_width(BUSY_CYC);
    localparam int LCW   = cnt_width(ACC_LAT);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic [BCW-1:0]    busy_cnt;
    logic [LCW-1:0]    lat_cnt;
    logic              pend_q;

    // Array access: store on write, capture the addressed word on read.
    always_ff @(posedge clk) begin
        if (acc_i) begin
            if (wr_i) mem[idx_i] <= wdata_i;
            else      rd_q       <= mem[idx_i];
        end
    end

    // Busy countdown: the bank refuses new accesses until it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_cnt <= '0;
        else if (acc_i)            busy_cnt <= BCW'(BUSY_CYC - 1);
        else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
    end

    // Latency countdown for the pending read.
    always_ff @(posedge clk) begin
        if (!rst_n)                lat_cnt <= '0;
        else if (acc_i && !wr_i)   lat_cnt <= LCW'(ACC_LAT - 1);
        else if (lat_cnt != '0)    lat_cnt <= lat_cnt - 1'b1;
    end

    // Pending flag: set by a read, cleared when the result is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (acc_i && !wr_i)   pend_q <= 1'b1;
        else if (pop_i)            pend_q <= 1'b0;
    end

    // Status outputs.
    always_comb begin
        busy_o  = (busy_cnt != '0);
        done_o  = pend_q && (lat_cnt == '0);
        rdata_o = rd_q;
    end
endmodule

// File: rtl/ilv_tag_fifo.sv
// Small FIFO of bank numbers, one entry per outstanding read, giving the
// order in which read results must be returned. Assumes DEPTH is a power of two.
module ilv_tag_fifo #(
    parameter int TAG_W = 2,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             pop_i,
    output logic [TAG_W-1:0] head_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int PW = $clog2(DEPTH);

    logic [TAG_W-1:0] slot [DEPTH];
    logic [PW:0]      wr_ptr, rd_ptr;

    // Entry storage.
    always_ff @(posedge clk) begin
        if (push_i) slot[wr_ptr[PW-1:0]] <= tag_i;
    end

    // Pointer update; an extra wrap bit separates full from empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_i) wr_ptr <= wr_ptr + 1'b1;
            if (pop_i)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Occupancy flags and head entry.
    always_comb begin
        empty_o = (wr_ptr == rd_ptr);
        full_o  = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
        head_o  = slot[rd_ptr[PW-1:0]];
    end
endmodule

// File: rtl/ilv_mem_ctrl.sv
// Word-interleaved controller over NUM_BANKS banks. It accepts one request per
// cycle, steers it by the bank bits of the address, stalls while the target
// bank is busy and returns read data in issue order through a registered beat.
// Assumes NUM_BANKS and FIFO_DEPTH are powers of two and BUSY_CYC >= ACC_LAT >= 1.
module ilv_mem_ctrl
    import ilv_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int NUM_BANKS  = 4,
    parameter int ACC_LAT    = 4,
    parameter int BUSY_CYC   = 6,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int IDX_W  = ADDR_W - WORD_OFF_BITS - BANK_W;

    logic [BANK_W-1:0]    sel_bank;
    logic [IDX_W-1:0]     sel_idx;
    logic                 accept;
    logic                 fifo_full, fifo_empty;
    logic [BANK_W-1:0]    head_bank;
    logic                 head_done;
    logic [NUM_BANKS-1:0] busy_vec, done_vec, acc_vec, pop_vec;
    logic [DATA_W-1:0]    rdata_arr [NUM_BANKS];
    logic                 rsp_v_q;
    logic [DATA_W-1:0]    rsp_d_q;

    ilv_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_split (
        .addr_i (req_addr),
        .bank_o (sel_bank),
        .idx_o  (sel_idx)
    );

    // Handshake: ready when the target bank is idle and the order queue has room.
    always_comb begin
        req_ready = !busy_vec[sel_bank] && !fifo_full;
        accept    = req_valid && req_ready;
        head_done = !fifo_empty && done_vec[head_bank];
    end

    // Per-bank steering of accepts and result pops.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            acc_vec[b] = accept && (sel_bank == BANK_W'(b));
            pop_vec[b] = head_done && (head_bank == BANK_W'(b));
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ilv_bank #(
            .DATA_W(DATA_W), .IDX_W(IDX_W), .ACC_LAT(ACC_LAT), .BUSY_CYC(BUSY_CYC)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_i   (acc_vec[g]),
            .wr_i    (req_write),
            .idx_i   (sel_idx),
            .wdata_i (req_wdata),
            .pop_i   (pop_vec[g]),
            .busy_o  (busy_vec[g]),
            .done_o  (done_vec[g]),
            .rdata_o (rdata_arr[g])
        );
    end

    ilv_tag_fifo #(.TAG_W(BANK_W), .DEPTH(FIFO_DEPTH)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (accept && !req_write),
        .tag_i   (sel_bank),
        .pop_i   (head_done),
        .head_o  (head_bank),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    // Response register: one beat per completed read, in queue order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            rsp_v_q <= head_done;
            if (head_done) rsp_d_q <= rdata_arr[head_bank];
        end
    end

    // Output drive.
    always_comb begin
        rsp_valid = rsp_v_q;
        rsp_rdata = rsp_d_q;
    end
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
// Protocol checker for ilv_mem_ctrl, observing ports only. It keeps its own
// per-bank cycle counters and an outstanding-read count.
module ilv_mem_ctrl_chk
    import ilv_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_BANKS  = 4,
    parameter int ACC_LAT    = 4,
    parameter int BUSY_CYC   = 6,
    parameter int FIFO_DEPTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int GW     = cnt_width(BUSY_CYC);

    logic [BANK_W-1:0] bank;
    logic [GW-1:0]     gap [NUM_BANKS];
    logic [7:0]        outstanding;
    logic              acc;

    // Observed bank field and handshake.
    always_comb begin
        bank = req_addr[WORD_OFF_BITS +: BANK_W];
        acc  = req_valid && req_ready;
    end

    // Outstanding reads as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= '0;
        else outstanding <= outstanding + {7'd0, acc && !req_write} - {7'd0, rsp_valid};
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_gap
        // Edges since the last accept to this bank, saturating at BUSY_CYC.
        always_ff @(posedge clk) begin
            if (!rst_n)                               gap[g] <= GW'(BUSY_CYC);
            else if (acc && bank == BANK_W'(g))       gap[g] <= GW'(1);
            else if (gap[g] < GW'(BUSY_CYC))          gap[g] <= gap[g] + 1'b1;
        end

        AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && bank == BANK_W'(g)) |-> (gap[g] >= GW'(BUSY_CYC))); // R3
    end

    AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((gap[bank] >= GW'(BUSY_CYC)) && (outstanding < 8'(FIFO_DEPTH))) |-> req_ready); // R4

    AST_RSP_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (outstanding != '0)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= 8'(ACC_LAT + 1)); // R5
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .ACC_LAT(ACC_LAT),
    .BUSY_CYC(BUSY_CYC), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid)
);

// File: tb/ilv_mem_ctrl_test.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a bench-side memory model and timing rules.
module ilv_mem_ctrl_test;
    localparam int DATA_W = 32, ADDR_W = 12, NB = 4, LAT = 4, BUSY = 6;
    localparam int WORDS = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;

    int errors = 0, checks = 0, cyc = 0, reads = 0, resps = 0;
    logic [DATA_W-1:0] model [WORDS];
    int last_acc [NB];
    logic [DATA_W-1:0] exp_q [$];
    int cyc_q [$];
    logic done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ilv_mem_ctrl uut (.*);

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int bank_of(input logic [ADDR_W-1:0] a);
        return int'(a[3:2]);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request; returns the cycle count seen just before the accepting edge.
    task automatic issue(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, output int acc_c);
        bit r;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        forever begin
            #1;
            r = req_ready;
            acc_c = cyc;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        // R3: same-bank spacing observed at every accept
        if (last_acc[bank_of(a)] >= 0)
            check(acc_c - last_acc[bank_of(a)] >= BUSY, "R3", acc_c - last_acc[bank_of(a)], BUSY);
        last_acc[bank_of(a)] = acc_c;
        if (wr) model[a[ADDR_W-1:2]] = d;
        else begin
            exp_q.push_back(model[a[ADDR_W-1:2]]);
            cyc_q.push_back(acc_c);
            reads++;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Response monitor: order, data and latency (R5, R6, R7).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            resps++;
            if (exp_q.size() == 0) check(1'b0, "R6", 1, 0);
            else begin
                check(rsp_rdata == exp_q[0], "R7", rsp_rdata, exp_q[0]);
                check(cyc == cyc_q[0] + 1 + LAT, "R5", cyc, cyc_q[0] + 1 + LAT);
                void'(exp_q.pop_front());
                void'(cyc_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c0, c1, c2, c3, cx;
        process::self().srandom(32'd7);
        for (int b = 0; b < NB; b++) last_acc[b] = -1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(req_ready == 1'b1, "R1", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", rsp_valid, 0);

        // Fill every word so later reads are defined.
        for (int i = 0; i < WORDS; i++) issue(1'b1, ADDR_W'(i * 4), $urandom, cx);
        idle(8);

        // R2: byte offset ignored
        issue(1'b1, 12'h045, 32'hCAFE_0045, cx);
        issue(1'b0, 12'h044, 32'h0, cx);
        idle(10);
        check(model[12'h044 >> 2] == 32'hCAFE_0045 && exp_q.size() == 0, "R2", exp_q.size(), 0);

        // R3: read right after write to the same bank waits exactly BUSY edges
        idle(8);
        issue(1'b1, 12'h000, 32'h1234_5678, c0);
        issue(1'b0, 12'h000, 32'h0, c1);
        check(c1 - c0 == BUSY, "R3", c1 - c0, BUSY);
        idle(10);

        // R4: four banks back to back
        issue(1'b0, 12'h100, 0, c0);
        issue(1'b0, 12'h104, 0, c1);
        issue(1'b0, 12'h108, 0, c2);
        issue(1'b0, 12'h10C, 0, c3);
        check(c1 == c0 + 1 && c2 == c1 + 1 && c3 == c2 + 1, "R4", c3 - c0, 3);
        // R8: stalled read to bank 0 held and accepted once free
        issue(1'b0, 12'h110, 0, cx);
        check(cx - c0 == BUSY, "R8", cx - c0, BUSY);
        idle(12);

        // Random traffic: strides, same-bank runs and bubbles.
        for (int i = 0; i < 3000; i++) begin
            logic [ADDR_W-1:0] a;
            int m = $urandom_range(0, 9);
            if (m < 4)      a = ADDR_W'(($urandom_range(0, WORDS - 1)) * 4 + $urandom_range(0, 3));
            else if (m < 7) a = ADDR_W'((i * 4) % (WORDS * 4));
            else            a = ADDR_W'(($urandom_range(0, WORDS / 4 - 1)) * 16 + 8);
            issue($urandom_range(0, 9) < 4, a, $urandom, cx);
            if ($urandom_range(0, 15) == 0) idle($urandom_range(1, 3));
        end
        idle(20);

        // R6: one response per read, none left over
        check(resps == reads, "R6", resps, reads);
        check(exp_q.size() == 0, "R6", exp_q.size(), 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule